// File: doc/BRIEF.md
# Receive Character Buffer with Mode-Selected Ready Flag

This block sits between the deserialiser of one serial channel and the host. Each completed character is offered on a one-cycle strobe and placed in a three-entry first-in first-out store. The host sees the oldest character on a combinational read port and pops it with a one-cycle read strobe. If the store is full, one more character can wait in a holding stage. That stage empties into the store on its own as soon as a slot is free.

The block drives one registered ready output. A mode input selects what it means. In availability mode the output is high while any character is buffered. In full mode it rises when a write fills the last slot, and it falls when the host pops. A character that arrives while both the store and the holding stage are occupied is discarded, and a one-cycle overrun pulse reports the loss.

Top module: `rx_char_buffer`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, rdy_o is 0, overrun_o is 0 and rd_data_o is 0.
- R2: Characters leave in the order they arrived, including any that passed through the holding stage. Whenever the store is not empty, rd_data_o shows the oldest character. An rd_i high at a clock edge pops that character.
- R3: The store never holds more than three characters. A character that completes while the store is full and the holding stage is empty goes into the holding stage.
- R4: With mode_full_i = 0, after every edge rdy_o is 1 if the store holds at least one character and 0 if it is empty. This includes the case where characters remain after a pop.
- R5: With mode_full_i = 1, rdy_o stays 0 while the store holds one or two characters. It becomes 1 after the edge at which a write fills the third slot, and it becomes 0 after the edge at which the host pops.
- R6: A character in the holding stage moves into the store at the first edge at which the store count, as registered before that edge, is below three. In full mode rdy_o becomes 1 again after that edge when the move fills the store.
- R7: A character that completes while the store is full and the holding stage is occupied is discarded. overrun_o is 1 for exactly the cycle after that edge. The characters already buffered are unchanged.
- R8: With the store empty, rd_data_o is 0, and rd_i has no effect on the contents, the order or rdy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_full_i | input | 1 | Ready-flag meaning: 0 = character available, 1 = store full |
| char_valid_i | input | 1 | One-cycle strobe for a completed character |
| char_data_i | input | DATA_W | Completed character |
| rd_i | input | 1 | Host pop strobe |
| rd_data_o | output | DATA_W | Oldest buffered character, 0 when the store is empty |
| rdy_o | output | 1 | Ready flag, with its meaning set by mode_full_i |
| overrun_o | output | 1 | One-cycle pulse when a character is discarded |

## Verification
The hardest state to reach from the ports is a full store with an occupied holding stage in full mode, followed by a pop. In that state the flag must fall on one edge and rise again on the next, when the waiting character drains in. The stimulus reaches this state by sending four characters on consecutive cycles with no reads and then issuing a single pop. The bench samples rdy_o after each of the two edges that follow. A fifth character, sent with nothing read, reaches the drop case, where the overrun pulse must appear and the buffered order must stay intact.

// File: rtl/rx_buf_pkg.sv
package rx_buf_pkg;
  typedef enum logic {
    FLAG_AVAIL = 1'b0,
    FLAG_FULL  = 1'b1
  } flag_mode_e;
endpackage

// File: rtl/rx_buf_store.sv
module rx_buf_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              rd_i,
  output logic              pop_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pop;

  assign pop       = rd_i && (cnt_q != '0);
  assign pop_o     = pop;
  assign cnt_o     = cnt_q;
  assign rd_data_o = (cnt_q != '0) ? mem_q[rd_ptr_q] : '0;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[g] <= '0;
      else if (push_i && wr_ptr_q == PTR_W'(g))     mem_q[g] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop)    rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q != CNT_FULL));
  assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);
  assert_empty_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !push_i) |=> (cnt_q == '0 && $stable(rd_ptr_q)));
endmodule

// File: rtl/rx_buf_hold.sv
module rx_buf_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_valid_i,
  input  logic [DATA_W-1:0] char_data_i,
  input  logic              store_full_i,
  output logic              push_o,
  output logic [DATA_W-1:0] push_data_o,
  output logic              hold_valid_o,
  output logic              overrun_o
);
  logic              hold_valid_q, overrun_q;
  logic [DATA_W-1:0] hold_data_q;
  logic              drain, drop, park;

  // the holding stage always drains first to keep arrival order
  assign drain       = hold_valid_q && !store_full_i;
  assign drop        = char_valid_i && hold_valid_q && store_full_i;
  assign park        = char_valid_i && (hold_valid_q || store_full_i) && !drop;
  assign push_o      = (hold_valid_q || char_valid_i) && !store_full_i;
  assign push_data_o = hold_valid_q ? hold_data_q : char_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_valid_q <= 1'b0;
      hold_data_q  <= '0;
      overrun_q    <= 1'b0;
    end else begin
      overrun_q <= drop;
      if (park) begin
        hold_valid_q <= 1'b1;
        hold_data_q  <= char_data_i;
      end else if (drain) begin
        hold_valid_q <= 1'b0;
      end
    end
  end

  assign hold_valid_o = hold_valid_q;
  assign overrun_o    = overrun_q;

  assert_drop_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> (hold_valid_q && $stable(hold_data_q)));
  assert_park_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && store_full_i && !hold_valid_q) |=> hold_valid_q);
endmodule

// File: rtl/rx_buf_flag.sv
module rx_buf_flag #(
  parameter int DEPTH = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_full_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             rdy_o
);
  import rx_buf_pkg::*;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_next;
  logic             fill_evt, rdy_q, rdy_d;
  flag_mode_e       mode;

  assign mode     = flag_mode_e'(mode_full_i);
  assign cnt_next = cnt_i + CNT_W'(push_i) - CNT_W'(pop_i);
  assign fill_evt = push_i && (cnt_next == CNT_FULL);

  always_comb begin
    unique case (mode)
      FLAG_AVAIL: rdy_d = (cnt_next != '0);
      FLAG_FULL:  rdy_d = fill_evt || (rdy_q && !pop_i && cnt_next == CNT_FULL);
      default:    rdy_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= 1'b0;
    else         rdy_q <= rdy_d;
  end
  assign rdy_o = rdy_q;

  assert_avail_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_full_i |=> (rdy_o == (cnt_i != '0)));
  assert_full_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_full_i && !rdy_o) |=> (!rdy_o || cnt_i == CNT_FULL));
  assert_full_pop_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_full_i && pop_i) |=> !rdy_o);
endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_full_i,
  input  logic              char_valid_i,
  input  logic [DATA_W-1:0] char_data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rdy_o,
  output logic              overrun_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic              push, pop, hold_valid, store_full;
  logic [DATA_W-1:0] push_data;
  logic [CNT_W-1:0]  cnt;

  assign store_full = (cnt == CNT_FULL);

  rx_buf_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i, .rst_ni, .char_valid_i, .char_data_i,
    .store_full_i (store_full),
    .push_o       (push),
    .push_data_o  (push_data),
    .hold_valid_o (hold_valid),
    .overrun_o
  );

  rx_buf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .push_i      (push),
    .push_data_i (push_data),
    .rd_i,
    .pop_o       (pop),
    .cnt_o       (cnt),
    .rd_data_o
  );

  rx_buf_flag #(.DEPTH(DEPTH)) u_flag (
    .clk_i, .rst_ni, .mode_full_i,
    .push_i (push),
    .pop_i  (pop),
    .cnt_i  (cnt),
    .rdy_o
  );

  assert_hold_drain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_valid && !store_full && !pop) |=> (cnt == $past(cnt) + 1'b1));
  assert_overrun_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> $past(char_valid_i && hold_valid && store_full));
  assert_overrun_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> !overrun_o || $past(char_valid_i));
endmodule

// File: tb/rx_char_buffer_test.sv
module rx_char_buffer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_full = 1'b0, cv = 1'b0, rd = 1'b0;
  logic [DW-1:0] cd = '0;
  logic [DW-1:0] rd_data;
  logic rdy, ovr;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_char_buffer #(.DATA_W(DW), .DEPTH(3)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_full_i(mode_full),
    .char_valid_i(cv), .char_data_i(cd), .rd_i(rd),
    .rd_data_o(rd_data), .rdy_o(rdy), .overrun_o(ovr));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a negedge, let one posedge pass, return at the next negedge
  task automatic step(logic v, logic [DW-1:0] d, logic r);
    cv = v; cd = d; rd = r;
    @(negedge clk);
    cv = 1'b0; cd = '0; rd = 1'b0;
  endtask

  task automatic do_reset(logic m);
    mode_full = m;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    mode_full = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk("R1 rdy", rdy, 0); chk("R1 ovr", ovr, 0); chk("R1 data", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdy after", rdy, 0); chk("R1 data after", rd_data, 0);
  endtask

  task automatic t_avail_order;
    do_reset(1'b0);
    step(1, 8'h11, 0);
    chk("R4 rdy one", rdy, 1); chk("R2 head", rd_data, 8'h11);
    step(1, 8'h22, 0);
    step(1, 8'h33, 0);
    chk("R2 head kept", rd_data, 8'h11);
    step(0, 0, 1);
    chk("R4 rdy remain", rdy, 1); chk("R2 second", rd_data, 8'h22);
    step(0, 0, 1);
    chk("R2 third", rd_data, 8'h33);
    step(0, 0, 1);
    chk("R4 rdy empty", rdy, 0); chk("R8 data empty", rd_data, 0);
  endtask

  task automatic t_full_mode;
    do_reset(1'b1);
    step(1, 8'hA1, 0);
    chk("R5 one", rdy, 0);
    step(1, 8'hA2, 0);
    chk("R5 two", rdy, 0);
    step(1, 8'hA3, 0);
    chk("R5 filled", rdy, 1);
    step(1, 8'hA4, 0);
    chk("R3 held, head", rd_data, 8'hA1); chk("R3 no overrun", ovr, 0);
    chk("R5 still", rdy, 1);
    step(0, 0, 1);
    chk("R5 pop clears", rdy, 0); chk("R2 next", rd_data, 8'hA2);
    step(0, 0, 0);
    chk("R6 refill sets", rdy, 1);
    step(0, 0, 1); chk("R2 b", rd_data, 8'hA3);
    step(0, 0, 1); chk("R6 held order", rd_data, 8'hA4);
    step(0, 0, 1); chk("R8 empty", rd_data, 0); chk("R5 empty rdy", rdy, 0);
  endtask

  task automatic t_overrun;
    do_reset(1'b0);
    for (int i = 1; i <= 4; i++) step(1, DW'(8'h40 + i), 0);
    chk("R7 no ovr yet", ovr, 0);
    step(1, 8'h4F, 0);
    chk("R7 ovr pulse", ovr, 1);
    step(0, 0, 0);
    chk("R7 ovr ends", ovr, 0);
    for (int i = 1; i <= 4; i++) begin
      chk("R7 kept", rd_data, DW'(8'h40 + i));
      step(0, 0, 1);
    end
    chk("R7 dropped gone", rd_data, 0); chk("R4 empty", rdy, 0);
  endtask

  task automatic t_empty_read;
    do_reset(1'b0);
    step(0, 0, 1);
    chk("R8 data", rd_data, 0); chk("R8 rdy", rdy, 0);
    step(0, 0, 1);
    step(1, 8'h5A, 0);
    chk("R8 after", rd_data, 8'h5A); chk("R8 rdy one", rdy, 1);
    step(0, 0, 1);
    chk("R8 drained", rdy, 0);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset();
        t_avail_order();
        t_full_mode();
        t_overrun();
        t_empty_read();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule